// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two signed two's complement operands of configurable width and returns the full-width signed product. One operand, the multiplier, is split into overlapping three-bit windows that step by two bit positions. Each window becomes a signed digit in the range −2 to +2. Each digit picks a shifted, possibly negated copy of the other operand, the multiplicand, as one partial product. A multiplier operand of N bits therefore produces ceil(N/2) partial products, roughly half as many as a bit-by-bit array.

The partial products are extended to the full product width and compressed by layers of 3:2 carry-save compressors until only a sum vector and a carry vector remain. One carry-propagate adder then resolves those two vectors into the product. Negation costs one inversion per row plus a single correction row that collects all the +1 bits, so no row carries its own incrementer. A parameter selects between a registered product, with clock enable and asynchronous reset, and a purely combinational product.

Top module: `booth_mult`

## Requirements
- R1: `prod` is `MCAND_W + MPLR_W` bits wide and equals the exact two's complement product of `mcand` and `mplr` for every input pair. This includes the case where both operands hold their most negative value.
- R2: Digit i of the multiplier is taken from the bits (y[2i+1], y[2i], y[2i−1]), with y[−1] = 0. The code maps 000 to 0, 001 and 010 to +1, 011 to +2, 100 to −2, 101 and 110 to −1, and 111 to 0. No digit selects the 1× and the 2× multiple at the same time, and a negated digit never selects zero.
- R3: An odd multiplier width is sign-extended by one bit before grouping. The block forms exactly ceil(MPLR_W/2) partial products, and the product stays exact.
- R4: A negative digit is applied as the bit inverse of the selected multiple plus a +1 at that row's least significant position. This stays exact when the multiplicand is at its most negative value.
- R5: With `OUT_REG` = 1, the product of the inputs present at a rising edge with `en` high appears on `prod` after that edge. It does not appear before that edge.
- R6: With `OUT_REG` = 1, `prod` keeps its value across any rising edge at which `en` is low, whatever the operands are.
- R7: With `OUT_REG` = 1, `rst_n` low forces `prod` to zero at once, without waiting for a clock edge.
- R8: With `OUT_REG` = 0, `prod` follows the operands combinationally and ignores `clk`, `rst_n` and `en`.
- R9: A zero on either operand gives a zero product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| en | input | 1 | Capture enable for the output register |
| mcand | input | MCAND_W | Signed multiplicand |
| mplr | input | MPLR_W | Signed multiplier, Booth-recoded |
| prod | output | MCAND_W+MPLR_W | Signed product |

## Verification
The bench builds three instances.

- **8×8 registered:** every one of the 65,536 operand pairs is applied, so each recoding window value and every sign corner, including the most-negative square, is covered exactly.
- **16×16 combinational:** structured multiplier patterns drive each window code, and these run alongside random operands. This exercises a deeper compressor tree and the path without a register.
- **9×7 registered:** this instance has an odd multiplier width, which brings the sign-extension of the top window within reach.

The bench also exercises the output register's latency, its enable hold and its asynchronous reset.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // One recoded radix-4 digit: magnitude select plus sign.
  typedef struct packed {
    logic neg;
    logic two;
    logic one;
  } bdigit_t;

  // Map a three-bit window to a signed digit in {-2..+2}.
  function automatic bdigit_t recode(input logic [2:0] win);
    bdigit_t d;
    d = '0;
    case (win)
      3'b001, 3'b010: d.one = 1'b1;
      3'b011:         d.two = 1'b1;
      3'b100:         begin d.two = 1'b1; d.neg = 1'b1; end
      3'b101, 3'b110: begin d.one = 1'b1; d.neg = 1'b1; end
      default:        d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder #(
  parameter int MPLR_W = 16,
  localparam int EXT_W = MPLR_W + (MPLR_W % 2),
  localparam int NPP   = EXT_W / 2
) (
  input  logic [MPLR_W-1:0]              mplr_i,
  output booth_pkg::bdigit_t [NPP-1:0]   digits_o
);

  // Operand widened to an even width, with the implicit zero below bit 0.
  logic [EXT_W:0] win_src;

  generate
    if (EXT_W != MPLR_W) begin : g_odd
      assign win_src = {mplr_i[MPLR_W-1], mplr_i, 1'b0};
    end else begin : g_even
      assign win_src = {mplr_i, 1'b0};
    end
  endgenerate

  generate
    for (genvar i = 0; i < NPP; i++) begin : g_dig
      assign digits_o[i] = booth_pkg::recode(win_src[2*i+2 : 2*i]);
    end
  endgenerate

endmodule

// File: rtl/booth_ppgen.sv
module booth_ppgen #(
  parameter int MCAND_W = 16,
  parameter int PW      = 32,
  parameter int SHIFT   = 0
) (
  input  logic [MCAND_W-1:0]   mcand_i,
  input  booth_pkg::bdigit_t   digit_i,
  output logic [PW-1:0]        row_o
);

  logic [PW-1:0] base;
  logic [PW-1:0] mult;

  // Full-width sign extension so every row is exact modulo 2^PW.
  assign base = {{(PW-MCAND_W){mcand_i[MCAND_W-1]}}, mcand_i};

  always_comb begin
    if (digit_i.two)      mult = base << 1;
    else if (digit_i.one) mult = base;
    else                  mult = '0;
    // Inversion only; the +1 lives in the shared correction row.
    row_o = (mult ^ {PW{digit_i.neg}}) << SHIFT;
  end

endmodule

// File: rtl/booth_csa_tree.sv
module booth_csa_tree #(
  parameter int W    = 32,
  parameter int ROWS = 9
) (
  input  logic [W-1:0] rows_i [ROWS],
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);

  function automatic int after_level(input int n);
    return (n / 3) * 2 + (n % 3);
  endfunction

  function automatic int rows_at(input int lvl);
    int n;
    n = ROWS;
    for (int l = 0; l < lvl; l++) n = after_level(n);
    return n;
  endfunction

  function automatic int level_count();
    int n;
    int c;
    n = ROWS;
    c = 0;
    while (n > 2) begin
      n = after_level(n);
      c++;
    end
    return c;
  endfunction

  localparam int LEVELS = level_count();

  logic [W-1:0] stage [LEVELS+1][ROWS];

  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_in
      assign stage[0][r] = rows_i[r];
    end

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
      localparam int N  = rows_at(lv);
      localparam int G  = N / 3;
      localparam int NN = rows_at(lv + 1);

      // Each group of three rows becomes a sum row and a shifted carry row.
      for (genvar g = 0; g < G; g++) begin : g_fa
        assign stage[lv+1][2*g]   = stage[lv][3*g] ^ stage[lv][3*g+1] ^ stage[lv][3*g+2];
        assign stage[lv+1][2*g+1] = ((stage[lv][3*g]   & stage[lv][3*g+1]) |
                                     (stage[lv][3*g]   & stage[lv][3*g+2]) |
                                     (stage[lv][3*g+1] & stage[lv][3*g+2])) << 1;
      end

      // Rows left over from the grouping pass straight through.
      for (genvar r = 0; r < N % 3; r++) begin : g_pass
        assign stage[lv+1][2*G+r] = stage[lv][3*G+r];
      end

      for (genvar r = NN; r < ROWS; r++) begin : g_idle
        assign stage[lv+1][r] = '0;
      end
    end
  endgenerate

  assign sum_o   = stage[LEVELS][0];
  assign carry_o = stage[LEVELS][1];

endmodule

// File: rtl/booth_cpa.sv
module booth_cpa #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);

  // Single carry-propagate stage; the carry out of the top bit is dropped (mod 2^W).
  assign sum_o = a_i + b_i;

endmodule

// File: rtl/booth_mult.sv
module booth_mult #(
  parameter int MCAND_W = 16,
  parameter int MPLR_W  = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic [MCAND_W-1:0]          mcand,
  input  logic [MPLR_W-1:0]           mplr,
  output logic [MCAND_W+MPLR_W-1:0]   prod
);

  localparam int PW    = MCAND_W + MPLR_W;
  localparam int EXT_W = MPLR_W + (MPLR_W % 2);
  localparam int NPP   = EXT_W / 2;
  localparam int ROWS  = NPP + 1;

  booth_pkg::bdigit_t [NPP-1:0] digits;
  logic [PW-1:0] pp_rows [ROWS];
  logic [PW-1:0] corr_row;
  logic [PW-1:0] tree_sum;
  logic [PW-1:0] tree_carry;
  logic [PW-1:0] comb_prod;

  booth_recoder #(.MPLR_W(MPLR_W)) u_rec (
    .mplr_i   (mplr),
    .digits_o (digits)
  );

  generate
    for (genvar i = 0; i < NPP; i++) begin : g_pp
      booth_ppgen #(.MCAND_W(MCAND_W), .PW(PW), .SHIFT(2*i)) u_pp (
        .mcand_i (mcand),
        .digit_i (digits[i]),
        .row_o   (pp_rows[i])
      );
    end
  endgenerate

  // All +1 negation corrections share one row, one bit per digit.
  always_comb begin
    corr_row = '0;
    for (int i = 0; i < NPP; i++) corr_row[2*i] = digits[i].neg;
  end

  assign pp_rows[NPP] = corr_row;

  booth_csa_tree #(.W(PW), .ROWS(ROWS)) u_tree (
    .rows_i  (pp_rows),
    .sum_o   (tree_sum),
    .carry_o (tree_carry)
  );

  booth_cpa #(.W(PW)) u_cpa (
    .a_i   (tree_sum),
    .b_i   (tree_carry),
    .sum_o (comb_prod)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic [PW-1:0] prod_q;
      logic [PW-1:0] prod_nxt;

      always_comb begin
        prod_nxt = prod_q;
        if (en) prod_nxt = comb_prod;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prod_q <= '0;
        else        prod_q <= prod_nxt;
      end

      assign prod = prod_q;
    end else begin : g_comb
      assign prod = comb_prod;
    end
  endgenerate

endmodule

// File: rtl/booth_mult_chk.sv
module booth_mult_chk #(
  parameter int MCAND_W = 16,
  parameter int MPLR_W  = 16,
  parameter bit OUT_REG = 1'b1,
  localparam int PW  = MCAND_W + MPLR_W,
  localparam int NPP = (MPLR_W + (MPLR_W % 2)) / 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       en,
  input logic [MCAND_W-1:0]         mcand,
  input logic [MPLR_W-1:0]          mplr,
  input logic [PW-1:0]              prod,
  input booth_pkg::bdigit_t [NPP-1:0] digits,
  input logic [PW-1:0]              tree_sum,
  input logic [PW-1:0]              tree_carry
);

  function automatic logic [PW-1:0] ref_prod(input logic [MCAND_W-1:0] a,
                                             input logic [MPLR_W-1:0]  b);
    logic signed [PW-1:0] ea;
    logic signed [PW-1:0] eb;
    ea = {{MPLR_W{a[MCAND_W-1]}}, a};
    eb = {{MCAND_W{b[MPLR_W-1]}}, b};
    return ea * eb;
  endfunction

  // R1: the carry-save outputs, once added, match the exact product
  p_tree_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(tree_sum + tree_carry) == ref_prod(mcand, mplr));

  generate
    for (genvar i = 0; i < NPP; i++) begin : g_dig
      // R2: at most one magnitude per digit
      p_digit_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({digits[i].one, digits[i].two}));
      // R2: negation only with a non-zero magnitude
      p_digit_neg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        digits[i].neg |-> (digits[i].one || digits[i].two));
    end

    if (OUT_REG) begin : g_reg
      // R5: captured product matches the operands of the enabled edge
      p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> prod == $past(ref_prod(mcand, mplr)));
      // R6: disabled edges leave the output untouched
      p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(prod));
      // R9: zero operand captured gives zero
      p_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (mcand == '0 || mplr == '0)) |=> prod == '0);
      // R7: output is clear while reset is held
      always @(posedge clk) begin
        if (!rst_n) p_reset_clear_r7: assert (prod == '0);
      end
    end else begin : g_comb
      // R8: output tracks the operands with no register
      p_comb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        prod == ref_prod(mcand, mplr));
    end
  endgenerate

endmodule

bind booth_mult booth_mult_chk #(
  .MCAND_W (MCAND_W),
  .MPLR_W  (MPLR_W),
  .OUT_REG (OUT_REG)
) u_chk (.*);

// File: tb/sim_booth_mult.sv
`timescale 1ns/1ps
module sim_booth_mult;

  logic clk;
  logic rst_n;
  logic en;
  logic [7:0]  a0, b0;
  logic [15:0] a1, b1;
  logic [8:0]  a2;
  logic [6:0]  b2;
  logic [15:0] p0;
  logic [31:0] p1;
  logic [15:0] p2;

  int checks;
  int errors;
  longint last0, last2;
  longint q0[$], q1[$], q2[$];
  string  t0[$], t1[$], t2[$];

  booth_mult #(.MCAND_W(8),  .MPLR_W(8),  .OUT_REG(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .mcand(a0), .mplr(b0), .prod(p0));
  booth_mult #(.MCAND_W(16), .MPLR_W(16), .OUT_REG(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .en(en), .mcand(a1), .mplr(b1), .prod(p1));
  booth_mult #(.MCAND_W(9),  .MPLR_W(7),  .OUT_REG(1'b1)) u2 (
    .clk(clk), .rst_n(rst_n), .en(en), .mcand(a2), .mplr(b2), .prod(p2));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic signed [63:0] got,
                       input logic signed [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic string tag8(input logic [7:0] a, input logic [7:0] b);
    if (a == 8'h00 || b == 8'h00)      return "R9";
    if (a == 8'h80 && b == 8'h80)      return "R1";
    if (a == 8'h80)                    return "R4";
    return "R1";
  endfunction

  // Called at a falling edge: drive, model, check latency, then check one cycle later.
  task automatic step(input logic [7:0] na0, input logic [7:0] nb0,
                      input logic [15:0] na1, input logic [15:0] nb1,
                      input logic [8:0] na2, input logic [6:0] nb2,
                      input logic ne, input string tg1);
    longint prev0, prev2;
    prev0 = last0;
    prev2 = last2;
    a0 = na0; b0 = nb0; a1 = na1; b1 = nb1; a2 = na2; b2 = nb2; en = ne;
    if (ne) begin
      last0 = longint'($signed(na0)) * longint'($signed(nb0));
      last2 = longint'($signed(na2)) * longint'($signed(nb2));
      t0.push_back(tag8(na0, nb0));
      t2.push_back("R3");
    end else begin
      t0.push_back("R6");
      t2.push_back("R6");
    end
    q0.push_back(last0);
    q2.push_back(last2);
    q1.push_back(longint'($signed(na1)) * longint'($signed(nb1)));
    t1.push_back(tg1);
    #1;
    // R5: registered outputs have not moved before the capturing edge
    check("R5", $signed(p0), prev0);
    check("R5", $signed(p2), prev2);
    @(negedge clk);
    check(t0.pop_front(), $signed(p0), q0.pop_front());
    check(t1.pop_front(), $signed(p1), q1.pop_front());
    check(t2.pop_front(), $signed(p2), q2.pop_front());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] pat [10];
    logic [15:0] mc  [6];
    checks = 0;
    errors = 0;
    last0 = 0;
    last2 = 0;
    rst_n = 1'b0;
    en = 1'b0;
    a0 = '0; b0 = '0; a1 = '0; b1 = '0; a2 = '0; b2 = '0;
    pat = '{16'h0000, 16'h5555, 16'hAAAA, 16'h3333, 16'hCCCC,
            16'hFFFF, 16'h7FFF, 16'h8000, 16'h6666, 16'h9999};
    mc  = '{16'h7FFF, 16'h8000, 16'h0001, 16'hFFFF, 16'h1234, 16'hA5A5};

    repeat (3) @(negedge clk);
    a0 = 8'h7F; b0 = 8'h7F; a2 = 9'h0FF; b2 = 7'h3F; en = 1'b1;
    @(negedge clk);
    // R7: reset holds the registered products at zero
    check("R7", $signed(p0), 0);
    check("R7", $signed(p2), 0);
    rst_n = 1'b1;

    // R6: capture one value, then hold across disabled edges
    step(8'd5, 8'd7, 16'd3, 16'd4, 9'd11, 7'd13, 1'b1, "R8");
    for (int k = 0; k < 3; k++)
      step(8'h81, 8'h80, 16'hFFFF, 16'h8000, 9'h100, 7'h40, 1'b0, "R1");

    // R2: structured multiplier patterns exercise every window code
    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 6; j++)
        step(8'($urandom), 8'($urandom), mc[j], pat[i],
             9'($urandom), 7'($urandom), 1'b1, "R2");

    // R1 / R3 / R4 / R9: exhaustive 8x8, random 16x16 and 9x7 alongside
    for (int ai = 0; ai < 256; ai++)
      for (int bi = 0; bi < 256; bi++)
        step(8'(ai), 8'(bi), 16'($urandom), 16'($urandom),
             9'($urandom), 7'($urandom), 1'b1, "R8");

    // R3: odd-width corners through the 9x7 instance
    step(8'd1, 8'd1, 16'd0, 16'd5, 9'h100, 7'h40, 1'b1, "R9");
    step(8'd1, 8'd1, 16'd1, 16'd1, 9'h0FF, 7'h40, 1'b1, "R8");
    step(8'd1, 8'd1, 16'd1, 16'd1, 9'h100, 7'h3F, 1'b1, "R8");

    // R7: asynchronous reset mid-cycle clears without a clock edge
    #2;
    rst_n = 1'b0;
    #1;
    check("R7", $signed(p0), 0);
    check("R7", $signed(p2), 0);
    @(negedge clk);
    rst_n = 1'b1;
    last0 = 0;
    last2 = 0;
    step(8'h80, 8'h80, 16'h8000, 16'h8000, 9'h100, 7'h40, 1'b1, "R1");
    step(8'h00, 8'h33, 16'h0000, 16'h1234, 9'h000, 7'h11, 1'b1, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule